// File: doc/BRIEF.md
# I2C Controller Interrupt Status Block

This block gathers the interrupt causes of an I2C controller into one status word. Single-cycle event strobes from the receive and transmit queues and from the master and slave state machines set sticky status bits. Two bits instead follow threshold levels from the queues, and one follows the busy signal of the protocol engine. The raw word is never masked. A mask register gates it into a masked word, and the OR of the masked word drives one interrupt line.

Software clears status through read-only clear locations. Each source has its own location, and one further location clears every clearable source at once. Dropping the controller enable also clears the sticky causes. The exception is receive underflow, which waits while disabled until both state machines report idle. Register reads are combinational on a simple read/write port. A clear location returns zero, and its clear takes effect at the clock edge that ends the read cycle.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset every status bit is 0 (apart from the two level bits, which mirror their inputs), the mask reads 0xFFF and `irq` is low.
- R2: A read at byte offset 0x34 returns the raw word: bit 0 receive underflow, 1 receive overflow, 2 receive full, 3 transmit overflow, 4 transmit empty, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop seen, 10 start seen, 11 general call. Bits 31..12 read 0. The mask never alters this word.
- R3: Offset 0x30 is the mask (read/write, bits 11..0). Offset 0x2C returns raw AND mask. `irq` is high exactly when that masked word is non-zero.
- R4: A pulse on `evt_pulse[k]` for k in {1,3,5,6,7,9,10,11} sets raw bit k from the next cycle on, and the bit stays set after the pulse ends.
- R5: Raw bit 0 sets when `data_rd` is high in a cycle where `rxq_empty` is high. A data read while the queue is not empty leaves it unchanged.
- R6: A read of offset 0x44 + 4*k returns 0 and clears raw bit k only.
- R7: A read of offset 0x40 returns 0 and clears every sticky bit in the same edge.
- R8: If a set condition for bit k occurs in the same cycle as a clear read of that bit, the bit stays set.
- R9: Raw bits 2 and 4 equal `rxq_full_lvl` and `txq_empty_lvl` in every cycle, and no clear read affects them.
- R10: Raw bit 8 sets while `engine_busy` is high. A clear read removes it only in a cycle where `engine_busy` is low.
- R11: While `ctl_en` is low, every sticky bit except bit 0 clears unless its set condition is present in that cycle.
- R12: While `ctl_en` is low, raw bit 0 ignores clear reads and holds until `mst_idle` and `slv_idle` are both high, then clears.
- R13: `evt_pulse` bits 0, 2, 4 and 8 have no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_en | input | 1 | Controller enable |
| mst_idle | input | 1 | Master state machine is idle |
| slv_idle | input | 1 | Slave state machine is idle |
| engine_busy | input | 1 | Protocol engine is active |
| rxq_empty | input | 1 | Receive queue holds no data |
| data_rd | input | 1 | Host read of the data/command register this cycle |
| rxq_full_lvl | input | 1 | Receive queue at or above its threshold |
| txq_empty_lvl | input | 1 | Transmit queue at or below its threshold |
| evt_pulse | input | 12 | Event strobes, one per status bit position |
| reg_addr | input | 8 | Register byte offset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, zero when no read is active |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets a set strobe that collides with a clear read of the same bit. A design that lets the clear win would lose an event that arrived while software was acknowledging. It also targets a disabled controller with a pending underflow while one state machine is still busy. A design that clears on disable alone would drop that bit early, and one that honours clear reads in that state would let software erase it. Clear reads of the level bits and of activity while busy should have no effect, and a wrong clear path shows up as a bit that vanishes and comes back a cycle later. A zero mask over a non-zero raw word exposes any masking on the raw path.

// File: rtl/i2c_irq_pkg.sv
// Package: shared constants and types of the I2C interrupt status block.
// Assumes byte offsets fit the register address width chosen at the top.
package i2c_irq_pkg;

    localparam int NSRC = 12;

    localparam int B_RX_UNDER = 0;
    localparam int B_RX_OVER  = 1;
    localparam int B_RX_FULL  = 2;
    localparam int B_TX_OVER  = 3;
    localparam int B_TX_EMPTY = 4;
    localparam int B_RD_REQ   = 5;
    localparam int B_TX_ABRT  = 6;
    localparam int B_RX_DONE  = 7;
    localparam int B_ACTIVITY = 8;
    localparam int B_STOP     = 9;
    localparam int B_START    = 10;
    localparam int B_GCALL    = 11;

    localparam int OFS_MSTAT    = 'h2C;
    localparam int OFS_MASK     = 'h30;
    localparam int OFS_RAW      = 'h34;
    localparam int OFS_CLR_ALL  = 'h40;
    localparam int OFS_CLR_BASE = 'h44;
    localparam int CLR_STRIDE   = 4;

    // How a sticky bit reacts to a disabled controller
    typedef enum logic {
        KIND_EVENT = 1'b0,  // cleared while disabled
        KIND_HOLD  = 1'b1   // held while disabled until both machines idle
    } src_kind_e;

endpackage

// File: rtl/irq_sticky_bit.sv
// Module: one sticky status bit. A set condition always wins over any
// clear. KIND_EVENT bits drop on a clear read or while the controller is
// disabled. KIND_HOLD bits honour clear reads only while enabled; while
// disabled they drop once both state machines report idle.
// Assumes clr_i is already the OR of the per-source and global clears.
module irq_sticky_bit
    import i2c_irq_pkg::*;
#(
    parameter src_kind_e KIND = KIND_EVENT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    input  logic idle_i,
    output logic q_o
);

    localparam bit HOLD_MODE = (KIND == KIND_HOLD);

    logic drop;

    // Decide whether the bit may fall this cycle
    always_comb begin
        if (HOLD_MODE) begin
            drop = en_i ? clr_i : idle_i;
        end else begin
            drop = clr_i | ~en_i;
        end
    end

    // Hold the bit; set has priority over drop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (drop) begin
            q_o <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_mask_combine.sv
// Module: mask register, masked status and the combined interrupt line.
// The mask resets to all ones and is written whole by mask_we.
// Assumes raw_i is the unmasked status word.
module irq_mask_combine
    import i2c_irq_pkg::*;
#(
    parameter int W = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] masked_o,
    output logic         irq_o
);

    // Store the mask; all sources enabled out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    // Gate the raw word and reduce it to one line
    always_comb begin
        masked_o = raw_i & mask_q;
        irq_o    = |masked_o;
    end

endmodule

// File: rtl/irq_reg_decode.sv
// Module: register port decode. Reads are combinational and return zero
// outside a read cycle and at clear locations. A read of a clear location
// raises the matching bit of clr_o for that cycle.
// Assumes reg_rd and reg_wr are never high together.
module irq_reg_decode
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int W      = NSRC
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [W-1:0]      raw_i,
    input  logic [W-1:0]      masked_i,
    input  logic [W-1:0]      mask_i,
    output logic [W-1:0]      clr_o,
    output logic              mask_we,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam logic [ADDR_W-1:0] A_MSTAT   = ADDR_W'(OFS_MSTAT);
    localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_RAW     = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_CLR_ALL = ADDR_W'(OFS_CLR_ALL);
    localparam int               PAD       = DATA_W - W;

    logic clr_all;

    assign clr_all = reg_rd && (reg_addr == A_CLR_ALL);
    assign mask_we = reg_wr && (reg_addr == A_MASK);

    // One clear strobe per source location, plus the global one
    for (genvar k = 0; k < W; k++) begin : g_clr
        localparam logic [ADDR_W-1:0] A_CLR_K = ADDR_W'(OFS_CLR_BASE + CLR_STRIDE * k);
        assign clr_o[k] = clr_all | (reg_rd && (reg_addr == A_CLR_K));
    end

    // Select the word returned on a read
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == A_RAW) begin
                reg_rdata = {{PAD{1'b0}}, raw_i};
            end else if (reg_addr == A_MSTAT) begin
                reg_rdata = {{PAD{1'b0}}, masked_i};
            end else if (reg_addr == A_MASK) begin
                reg_rdata = {{PAD{1'b0}}, mask_i};
            end
        end
    end

endmodule

// File: rtl/i2c_irq_status.sv
// Module: interrupt status of an I2C controller. Builds the raw word from
// sticky event bits, two queue level bits and an activity bit; applies the
// mask and drives one interrupt line; decodes the register port.
// Assumes strobes are single-cycle and synchronous to clk.
module i2c_irq_status
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              mst_idle,
    input  logic              slv_idle,
    input  logic              engine_busy,
    input  logic              rxq_empty,
    input  logic              data_rd,
    input  logic              rxq_full_lvl,
    input  logic              txq_empty_lvl,
    input  logic [NSRC-1:0]   evt_pulse,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic [NSRC-1:0] raw_stat;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] masked;
    logic [NSRC-1:0] clr_vec;
    logic            mask_we;
    logic            both_idle;
    logic            unused_inputs;

    assign both_idle = mst_idle & slv_idle;

    // Strobe positions taken by other set sources, and the reserved data bits
    assign unused_inputs = evt_pulse[B_RX_UNDER] ^ evt_pulse[B_RX_FULL]
                         ^ evt_pulse[B_TX_EMPTY] ^ evt_pulse[B_ACTIVITY]
                         ^ (^reg_wdata[DATA_W-1:NSRC]);

    // Build each raw bit from its own kind of source
    for (genvar k = 0; k < NSRC; k++) begin : g_src
        if (k == B_RX_FULL) begin : g_rxlvl
            assign raw_stat[k] = rxq_full_lvl;
        end else if (k == B_TX_EMPTY) begin : g_txlvl
            assign raw_stat[k] = txq_empty_lvl;
        end else begin : g_stk
            logic set_k;
            if (k == B_RX_UNDER) begin : g_under
                assign set_k = data_rd & rxq_empty;
            end else if (k == B_ACTIVITY) begin : g_act
                assign set_k = engine_busy;
            end else begin : g_evt
                assign set_k = evt_pulse[k];
            end
            irq_sticky_bit #(
                .KIND ((k == B_RX_UNDER) ? KIND_HOLD : KIND_EVENT)
            ) u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_k),
                .clr_i  (clr_vec[k]),
                .en_i   (ctl_en),
                .idle_i (both_idle),
                .q_o    (raw_stat[k])
            );
        end
    end

    irq_mask_combine #(
        .W (NSRC)
    ) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (reg_wdata[NSRC-1:0]),
        .raw_i      (raw_stat),
        .mask_q     (mask_q),
        .masked_o   (masked),
        .irq_o      (irq)
    );

    irq_reg_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .W      (NSRC)
    ) u_dec (
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .raw_i     (raw_stat),
        .masked_i  (masked),
        .mask_i    (mask_q),
        .clr_o     (clr_vec),
        .mask_we   (mask_we),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/i2c_irq_status_chk.sv
// Module: assertion checker for i2c_irq_status, attached by bind below.
// Observes ports plus the raw word and mask held inside the top.
module i2c_irq_status_chk
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_en,
    input logic              mst_idle,
    input logic              slv_idle,
    input logic              engine_busy,
    input logic              rxq_full_lvl,
    input logic              txq_empty_lvl,
    input logic [NSRC-1:0]   evt_pulse,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic [NSRC-1:0]   raw_stat,
    input logic [NSRC-1:0]   mask_q
);

    localparam logic [ADDR_W-1:0] A_CLR_START = ADDR_W'(OFS_CLR_BASE + CLR_STRIDE * B_START);
    localparam logic [ADDR_W-1:0] A_CLR_OVER  = ADDR_W'(OFS_CLR_BASE + CLR_STRIDE * B_RX_OVER);

    // R4
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse[B_STOP] |=> raw_stat[B_STOP]);

    // R8
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse[B_START] && reg_rd && reg_addr == A_CLR_START) |=> raw_stat[B_START]);

    // R6
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_CLR_OVER) |-> (reg_rdata == '0));

    // R9
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[B_RX_FULL] == rxq_full_lvl) && (raw_stat[B_TX_EMPTY] == txq_empty_lvl));

    // R10
    busy_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        engine_busy |=> raw_stat[B_ACTIVITY]);

    // R12
    under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[B_RX_UNDER] && !ctl_en && !(mst_idle && slv_idle)) |=> raw_stat[B_RX_UNDER]);

    // R11
    gcall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !evt_pulse[B_GCALL]) |=> !raw_stat[B_GCALL]);

    // R3
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

endmodule

bind i2c_irq_status i2c_irq_status_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_en        (ctl_en),
    .mst_idle      (mst_idle),
    .slv_idle      (slv_idle),
    .engine_busy   (engine_busy),
    .rxq_full_lvl  (rxq_full_lvl),
    .txq_empty_lvl (txq_empty_lvl),
    .evt_pulse     (evt_pulse),
    .reg_addr      (reg_addr),
    .reg_rd        (reg_rd),
    .reg_rdata     (reg_rdata),
    .irq           (irq),
    .raw_stat      (raw_stat),
    .mask_q        (mask_q)
);

// File: tb/sim_i2c_irq_status.sv
// Bench: behavioural model of the status word, compared on every cycle.
module sim_i2c_irq_status;

    localparam int CLK_P = 10;
    localparam logic [7:0] A_MST = 8'h2C;
    localparam logic [7:0] A_MSK = 8'h30;
    localparam logic [7:0] A_RAW = 8'h34;
    localparam logic [7:0] A_ALL = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_en = 1'b1;
    logic        mst_idle = 1'b1;
    logic        slv_idle = 1'b1;
    logic        engine_busy = 1'b0;
    logic        rxq_empty = 1'b0;
    logic        data_rd = 1'b0;
    logic        rxq_full_lvl = 1'b0;
    logic        txq_empty_lvl = 1'b0;
    logic [11:0] evt_pulse = '0;
    logic [7:0]  reg_addr = 8'h34;
    logic        reg_rd = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    bit [11:0] m_stk = '0;
    bit [11:0] m_mask = 12'hFFF;

    always #(CLK_P / 2) clk = ~clk;

    i2c_irq_status u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_en        (ctl_en),
        .mst_idle      (mst_idle),
        .slv_idle      (slv_idle),
        .engine_busy   (engine_busy),
        .rxq_empty     (rxq_empty),
        .data_rd       (data_rd),
        .rxq_full_lvl  (rxq_full_lvl),
        .txq_empty_lvl (txq_empty_lvl),
        .evt_pulse     (evt_pulse),
        .reg_addr      (reg_addr),
        .reg_rd        (reg_rd),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq           (irq)
    );

    function automatic logic [7:0] clr_at(input int b);
        return 8'(8'h44 + 4 * b);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: compare outputs against the model, then advance the model
    task automatic tick(input string tag);
        bit [11:0] er;
        bit [11:0] nx;
        bit [11:0] nm;
        logic [31:0] ed;
        #1;
        er = m_stk;
        er[2] = rxq_full_lvl;
        er[4] = txq_empty_lvl;
        ed = '0;
        if (reg_rd) begin
            if (reg_addr == A_RAW) ed = {20'h0, er};
            else if (reg_addr == A_MST) ed = {20'h0, er & m_mask};
            else if (reg_addr == A_MSK) ed = {20'h0, m_mask};
        end
        chk(tag, "rdata", reg_rdata, ed);
        chk(tag, "irq", {31'h0, irq}, {31'h0, |(er & m_mask)});
        nm = m_mask;
        for (int b = 0; b < 12; b++) begin
            bit hit;
            bit setv;
            bit gone;
            hit = reg_rd && (reg_addr == A_ALL || reg_addr == clr_at(b));
            if (b == 0) setv = data_rd && rxq_empty;
            else if (b == 8) setv = engine_busy;
            else setv = evt_pulse[b];
            if (b == 0) gone = ctl_en ? hit : (mst_idle && slv_idle);
            else gone = hit || !ctl_en;
            if (b == 2 || b == 4) nx[b] = 1'b0;
            else if (setv) nx[b] = 1'b1;
            else if (gone) nx[b] = 1'b0;
            else nx[b] = m_stk[b];
        end
        if (reg_wr && reg_addr == A_MSK) nm = reg_wdata[11:0];
        @(posedge clk);
        m_stk = nx;
        m_mask = nm;
        @(negedge clk);
        evt_pulse = '0;
        data_rd = 1'b0;
        reg_rd = 1'b1;
        reg_wr = 1'b0;
        reg_addr = A_RAW;
        reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        reg_rd = 1'b1;
        reg_addr = a;
        tick(tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(A_RAW, "R1");
        rd(A_MSK, "R1");
        rd(A_MST, "R1");

        // R4 and R2: each event strobe sets its own bit
        foreach (evt_pulse[b]) begin
            if (b inside {1, 3, 5, 6, 7, 9, 10, 11}) begin
                evt_pulse[b] = 1'b1;
                tick("R4");
                rd(A_RAW, "R2");
            end
        end
        rd(A_MST, "R3");
        // R7: global clear
        rd(A_ALL, "R7");
        rd(A_RAW, "R7");

        // R13: strobes at positions of other sources do nothing
        evt_pulse = 12'h115;
        tick("R13");
        rd(A_RAW, "R13");

        // R5: data read with and without an empty queue
        data_rd = 1'b1;
        rxq_empty = 1'b0;
        tick("R5");
        rd(A_RAW, "R5");
        data_rd = 1'b1;
        rxq_empty = 1'b1;
        tick("R5");
        rd(A_RAW, "R5");
        rxq_empty = 1'b0;

        // R6: per-source clear touches only its bit
        evt_pulse = 12'h202;
        tick("R6");
        rd(clr_at(9), "R6");
        rd(A_RAW, "R6");
        rd(clr_at(0), "R6");
        rd(clr_at(1), "R6");
        rd(A_RAW, "R6");

        // R8: set in the same cycle as its clear
        evt_pulse[10] = 1'b1;
        tick("R8");
        evt_pulse[10] = 1'b1;
        rd(clr_at(10), "R8");
        rd(A_RAW, "R8");
        evt_pulse[7] = 1'b1;
        rd(A_ALL, "R8");
        rd(A_RAW, "R8");
        rd(A_ALL, "R8");

        // R9: level bits follow inputs and ignore clears
        rxq_full_lvl = 1'b1;
        txq_empty_lvl = 1'b1;
        rd(A_RAW, "R9");
        rd(A_ALL, "R9");
        rd(clr_at(2), "R9");
        rd(clr_at(4), "R9");
        rd(A_RAW, "R9");
        rxq_full_lvl = 1'b0;
        rd(A_RAW, "R9");

        // R3 and R2: masking
        reg_rd = 1'b0;
        reg_wr = 1'b1;
        reg_addr = A_MSK;
        reg_wdata = 32'hFFFF_F008;
        tick("R3");
        evt_pulse[3] = 1'b1;
        rd(A_MSK, "R3");
        rd(A_MST, "R3");
        reg_rd = 1'b0;
        reg_wr = 1'b1;
        reg_addr = A_MSK;
        reg_wdata = 32'h0;
        tick("R3");
        rd(A_MST, "R3");
        rd(A_RAW, "R2");
        reg_rd = 1'b0;
        reg_wr = 1'b1;
        reg_addr = A_MSK;
        reg_wdata = 32'hFFF;
        tick("R3");
        rd(A_ALL, "R3");
        txq_empty_lvl = 1'b0;

        // R10: activity follows busy
        engine_busy = 1'b1;
        tick("R10");
        rd(clr_at(8), "R10");
        rd(A_RAW, "R10");
        engine_busy = 1'b0;
        rd(A_RAW, "R10");
        rd(clr_at(8), "R10");
        rd(A_RAW, "R10");

        // R11: disable clears sticky causes, general call included
        evt_pulse = 12'hE22;
        tick("R11");
        rd(A_RAW, "R11");
        ctl_en = 1'b0;
        evt_pulse[6] = 1'b1;
        tick("R11");
        rd(A_RAW, "R11");
        rd(A_RAW, "R11");
        ctl_en = 1'b1;

        // R12: underflow held while disabled until both machines idle
        data_rd = 1'b1;
        rxq_empty = 1'b1;
        tick("R12");
        rxq_empty = 1'b0;
        ctl_en = 1'b0;
        mst_idle = 1'b0;
        rd(A_RAW, "R12");
        rd(clr_at(0), "R12");
        rd(A_ALL, "R12");
        mst_idle = 1'b1;
        slv_idle = 1'b0;
        rd(A_RAW, "R12");
        slv_idle = 1'b1;
        rd(A_RAW, "R12");
        rd(A_RAW, "R12");
        ctl_en = 1'b1;

        // Mixed random traffic, model compared every cycle
        for (int i = 0; i < 600; i++) begin
            int pick;
            evt_pulse = 12'($urandom);
            data_rd = 1'($urandom);
            rxq_empty = 1'($urandom);
            rxq_full_lvl = 1'($urandom);
            txq_empty_lvl = 1'($urandom);
            engine_busy = ($urandom % 4) == 0;
            ctl_en = ($urandom % 8) != 0;
            mst_idle = 1'($urandom);
            slv_idle = 1'($urandom);
            pick = int'($urandom % 8);
            reg_wr = 1'b0;
            reg_rd = 1'b1;
            case (pick)
                0: reg_addr = A_RAW;
                1: reg_addr = A_MST;
                2: reg_addr = A_MSK;
                3: reg_addr = A_ALL;
                4: begin
                    reg_rd = 1'b0;
                    reg_wr = 1'b1;
                    reg_addr = A_MSK;
                    reg_wdata = $urandom;
                end
                default: reg_addr = clr_at(int'($urandom % 12));
            endcase
            tick("R2 R8 R11 R12 mixed");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule